// File: doc/BRIEF.md
# Vectored Non-Nesting Interrupt Controller

This block gathers eight interrupt request lines for a small 8-bit processor core. The requests come from the timer overflow, two external pins, two counter underflows, the high and low pulse-width timer underflows, and a port input-change event. Each line is synchronized, and its falling edge is detected. When the source is unmasked, the edge latches a pending flag in a status register. The core reads and clears those flags and programs the mask through simple register ports. A global enable is raised by an enable-interrupt strobe and dropped by a disable-interrupt strobe.

When a flag is pending and unmasked, the global enable is on and no service routine is running, the controller takes the interrupt. It pulses `takeIrq` so that the core redirects its next fetch. It presents a fixed vector address for the winning source and pulses `saveStb` so that the hardware saves the accumulator and status register. It then stays in service until a return strobe arrives, and that return answers with `restoreStb`. Interrupts never nest. An edge that arrives during service stays pending and is taken once the routine has returned.

Source numbering, used by every data port: bit 0 timer overflow, bit 1 external pin 0, bit 2 external pin 1, bit 3 counter 1 underflow, bit 4 counter 2 underflow, bit 5 high pulse-width timer underflow, bit 6 low pulse-width timer underflow, bit 7 port input change.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the status flags, the mask, the global enable and the in-service state are all 0. The strobe outputs are low, `vecAddr` is 0, and a request line held high from reset sets no flag.
- R2: A falling edge on `irqIn[i]` sets status bit i, and the bit is visible on `statRdata` three clock edges after the input changes. A rising edge sets nothing.
- R3: A falling edge sets its status bit only while mask bit i is 1. A masked edge leaves `statRdata` at 0. `maskRdata` returns the value written through `maskWe`/`maskWdata`.
- R4: A status write clears each bit whose `statWdata` bit is 0 and leaves each bit whose `statWdata` bit is 1 unchanged. Software can never set a flag.
- R5: `eniStb` sets the global enable and `disiStb` clears it. When both arrive in the same cycle, the enable ends up cleared. No interrupt is taken while the enable is 0, even with flags pending.
- R6: When a pending unmasked flag exists, the enable is 1 and no routine is in service, `takeIrq` and `saveStb` pulse for one cycle on the next edge. At the same edge `inService` rises and `vecAddr` becomes 0x003 + 3*i for the winning source i (0x003, 0x006, ..., 0x018). `vecAddr` holds that value until the next take.
- R7: When several pending unmasked flags exist, the lowest-numbered source wins.
- R8: While `inService` is 1, no further interrupt is taken. A flag set during service stays pending and is taken on the second edge after the return strobe.
- R9: `retiStb` during service clears `inService` and pulses `restoreStb` on the next edge. `retiStb` while idle has no effect and produces no restore pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 8 | Request lines, falling-edge active, idle high |
| eniStb | input | 1 | Enable-interrupt instruction strobe |
| disiStb | input | 1 | Disable-interrupt instruction strobe |
| retiStb | input | 1 | Return-from-interrupt strobe |
| statWe | input | 1 | Status register write enable |
| statWdata | input | 8 | Status write data, 0 clears a flag |
| statRdata | output | 8 | Status flags |
| maskWe | input | 1 | Mask register write enable |
| maskWdata | input | 8 | Mask write data, 1 enables a source |
| maskRdata | output | 8 | Mask register value |
| takeIrq | output | 1 | One-cycle fetch-redirect request |
| vecAddr | output | 10 | Vector address of the taken source |
| saveStb | output | 1 | One-cycle save of accumulator and status register |
| restoreStb | output | 1 | One-cycle restore of accumulator and status register |
| inService | output | 1 | A service routine is running |

## Verification
The embedded assertions check on every cycle the following points. A new flag appears only where the mask was set. A take never happens while a routine is in service or while the global enable is off. A restore pulse only ever follows a return strobe during service. Every taken vector falls on the three-word grid inside 0x003 to 0x018. The directed scenarios are the only check on edge polarity and the three-edge latency, the clear-only status writes, priority among simultaneous flags, the dominance of the disable strobe, and a request that is held back during service and taken after return.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic latchVec;  // capture the winning vector this cycle
  } irqcStrb_t;
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int NUM_SRC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic [NUM_SRC-1:0] fallPulse
);
  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] prevQ;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gStage
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= '1;
        else if (s == 0) syncQ[s] <= reqIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '1;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign fallPulse = prevQ & ~syncQ[SYNC_STAGES-1];
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int ADDR_W   = 10,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] fallPulse,
  input  logic               statWe,
  input  logic [NUM_SRC-1:0] statWdata,
  input  logic               maskWe,
  input  logic [NUM_SRC-1:0] maskWdata,
  input  irqcStrb_t          strb,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic               pendAny,
  output logic [ADDR_W-1:0]  vecAddr
);
  localparam int VEC_LAST = VEC_BASE + VEC_STEP * (NUM_SRC - 1);

  logic [NUM_SRC-1:0] pendVec;
  logic [NUM_SRC-1:0] keepMask;
  logic [ADDR_W-1:0]  winVec;

  assign pendVec  = statusQ & maskQ;
  assign pendAny  = |pendVec;
  assign keepMask = statWe ? statWdata : '1;

  // Lowest-numbered pending source wins
  always_comb begin
    int winIdx;
    winIdx = 0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendVec[i]) winIdx = i;
    end
    winVec = ADDR_W'(VEC_BASE + VEC_STEP * winIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      vecAddr <= '0;
    end else begin
      statusQ <= (statusQ & keepMask) | (fallPulse & maskQ);
      if (maskWe) maskQ <= maskWdata;
      if (strb.latchVec) vecAddr <= winVec;
    end
  end

  // R3: a flag may only appear where the mask allowed it
  a_r3_mask_gate: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~$past(statusQ) & ~$past(maskQ)) == '0);

  // R6: a latched vector lies on the three-word grid
  a_r6_vec_grid: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchVec |=> (int'(vecAddr) >= VEC_BASE && int'(vecAddr) <= VEC_LAST
                       && ((int'(vecAddr) - VEC_BASE) % VEC_STEP) == 0));
endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      eniStb,
  input  logic      disiStb,
  input  logic      retiStb,
  input  logic      pendAny,
  output irqcStrb_t strb,
  output logic      takeIrq,
  output logic      saveStb,
  output logic      restoreStb,
  output logic      inService
);
  logic globalEn;
  logic canTake;

  assign canTake       = globalEn && !inService && pendAny;
  assign strb.latchVec = canTake;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn   <= 1'b0;
      inService  <= 1'b0;
      takeIrq    <= 1'b0;
      saveStb    <= 1'b0;
      restoreStb <= 1'b0;
    end else begin
      if (disiStb)     globalEn <= 1'b0;
      else if (eniStb) globalEn <= 1'b1;
      takeIrq    <= canTake;
      saveStb    <= canTake;
      restoreStb <= inService && retiStb;
      if (canTake)                    inService <= 1'b1;
      else if (inService && retiStb)  inService <= 1'b0;
    end
  end

  // R8: no take while a routine is in service
  a_r8_no_nest: assert property (@(posedge clk) disable iff (!rstN)
    inService |=> !takeIrq);

  // R5: a take requires the global enable
  a_r5_take_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(globalEn));

  // R9: restore only follows a return during service
  a_r9_restore_src: assert property (@(posedge clk) disable iff (!rstN)
    restoreStb |-> $past(inService && retiStb));

  // R6: a take enters service at once
  a_r6_take_enters: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> inService);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int ADDR_W      = 10,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               eniStb,
  input  logic               disiStb,
  input  logic               retiStb,
  input  logic               statWe,
  input  logic [NUM_SRC-1:0] statWdata,
  output logic [NUM_SRC-1:0] statRdata,
  input  logic               maskWe,
  input  logic [NUM_SRC-1:0] maskWdata,
  output logic [NUM_SRC-1:0] maskRdata,
  output logic               takeIrq,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic               saveStb,
  output logic               restoreStb,
  output logic               inService
);
  logic [NUM_SRC-1:0] fallPulse;
  logic               pendAny;
  irqcStrb_t          strb;

  irqc_edge #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rstN(rstN), .reqIn(irqIn), .fallPulse(fallPulse));

  irqc_datapath #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
                  .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .fallPulse(fallPulse),
    .statWe(statWe), .statWdata(statWdata),
    .maskWe(maskWe), .maskWdata(maskWdata), .strb(strb),
    .statusQ(statRdata), .maskQ(maskRdata), .pendAny(pendAny),
    .vecAddr(vecAddr));

  irqc_control u_ctl (
    .clk(clk), .rstN(rstN), .eniStb(eniStb), .disiStb(disiStb),
    .retiStb(retiStb), .pendAny(pendAny), .strb(strb),
    .takeIrq(takeIrq), .saveStb(saveStb), .restoreStb(restoreStb),
    .inService(inService));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = 8'hFF;
  logic       eniStb = 0, disiStb = 0, retiStb = 0;
  logic       statWe = 0, maskWe = 0;
  logic [7:0] statWdata = 0, maskWdata = 0;
  logic [7:0] statRdata, maskRdata;
  logic       takeIrq, saveStb, restoreStb, inService;
  logic [9:0] vecAddr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .eniStb(eniStb), .disiStb(disiStb),
    .retiStb(retiStb), .statWe(statWe), .statWdata(statWdata),
    .statRdata(statRdata), .maskWe(maskWe), .maskWdata(maskWdata),
    .maskRdata(maskRdata), .takeIrq(takeIrq), .vecAddr(vecAddr),
    .saveStb(saveStb), .restoreStb(restoreStb), .inService(inService));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStrobe(input int which);
    if (which == 0) eniStb = 1; else if (which == 1) disiStb = 1; else retiStb = 1;
    step(1);
    eniStb = 0; disiStb = 0; retiStb = 0;
  endtask

  task automatic writeStat(input logic [7:0] d);
    statWe = 1; statWdata = d; step(1); statWe = 0;
  endtask

  task automatic writeMask(input logic [7:0] d);
    maskWe = 1; maskWdata = d; step(1); maskWe = 0;
  endtask

  task automatic tReset;
    chk("R1", "status", statRdata, 0);
    chk("R1", "mask", maskRdata, 0);
    chk("R1", "take", takeIrq, 0);
    chk("R1", "save", saveStb, 0);
    chk("R1", "restore", restoreStb, 0);
    chk("R1", "inService", inService, 0);
    chk("R1", "vecAddr", vecAddr, 0);
  endtask

  task automatic tMasked;
    irqIn[2] = 0; step(5);
    chk("R3", "masked edge status", statRdata, 0);
    irqIn[2] = 1; step(4);
    writeMask(8'hFF);
    chk("R3", "mask readback", maskRdata, 8'hFF);
  endtask

  task automatic tEdge;
    irqIn[3] = 0; step(2);
    chk("R2", "status before 3rd edge", statRdata, 0);
    step(1);
    chk("R2", "status at 3rd edge", statRdata, 8'h08);
    irqIn[3] = 1; step(5);
    chk("R2", "rising edge sets nothing", statRdata, 8'h08);
    chk("R5", "no take while disabled", inService, 0);
  endtask

  task automatic tClear;
    writeStat(8'hF7);
    chk("R4", "write 0 clears", statRdata, 0);
    writeStat(8'hFF);
    chk("R4", "write 1 cannot set", statRdata, 0);
  endtask

  task automatic tTakeAndHold;
    pulseStrobe(0);
    irqIn[4] = 0; step(4);
    chk("R6", "take pulse", takeIrq, 1);
    chk("R6", "save pulse", saveStb, 1);
    chk("R6", "vector src4", vecAddr, 10'h00F);
    chk("R6", "inService", inService, 1);
    irqIn[4] = 1; step(1);
    chk("R6", "take one cycle", takeIrq, 0);
    irqIn[1] = 0; step(6);
    chk("R8", "no nested take", inService & ~takeIrq, 1);
    chk("R8", "held flag", statRdata, 8'h12);
    chk("R6", "vector held", vecAddr, 10'h00F);
    irqIn[1] = 1;
    writeStat(8'hEF);
    pulseStrobe(2);
    chk("R9", "restore pulse", restoreStb, 1);
    chk("R9", "service ends", inService, 0);
    chk("R8", "no take at return edge", takeIrq, 0);
    step(1);
    chk("R8", "pending taken after return", takeIrq, 1);
    chk("R8", "vector src1", vecAddr, 10'h006);
    writeStat(8'hFD);
    pulseStrobe(2);
    step(2);
  endtask

  task automatic tPriority;
    pulseStrobe(1);
    irqIn = 8'h3B; step(5);
    irqIn = 8'hFF;
    chk("R7", "three flags", statRdata, 8'hC4);
    chk("R5", "disabled no take", inService, 0);
    pulseStrobe(0);
    step(1);
    chk("R7", "lowest wins", vecAddr, 10'h009);
    writeStat(8'hFB); pulseStrobe(2); step(1);
    chk("R7", "next src6", vecAddr, 10'h015);
    writeStat(8'hBF); pulseStrobe(2); step(1);
    chk("R7", "last src7", vecAddr, 10'h018);
    chk("R6", "take for src7", takeIrq, 1);
    writeStat(8'h7F); pulseStrobe(2); step(2);
  endtask

  task automatic tDisiWinsAndIdleReti;
    pulseStrobe(2);
    chk("R9", "idle return no restore", restoreStb, 0);
    eniStb = 1; disiStb = 1; step(1); eniStb = 0; disiStb = 0;
    irqIn[0] = 0; step(6); irqIn[0] = 1;
    chk("R5", "disable dominates", inService, 0);
    chk("R2", "src0 flag", statRdata, 8'h01);
    pulseStrobe(0); step(1);
    chk("R6", "vector src0", vecAddr, 10'h003);
    chk("R6", "take src0", takeIrq, 1);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(4);
    rstN = 1;
    step(2);
    tReset();
    tMasked();
    tEdge();
    tClear();
    tTakeAndHold();
    tPriority();
    tDisiWinsAndIdleReti();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule